// File: doc/BRIEF.md
# Cache Line Burst Fill Controller

This block is the bus-side sequencer that sits between a cache and an external memory reached over a Wishbone-style handshake (cyc, stb, ack, err). When the cache reports a line miss, the requester pulses a request with the line flag set. The controller then reads every word of the line in ascending order, starting at the line-aligned address. Each returned word goes back to the cache together with its index inside the line. A request with the line flag clear performs one uncached word fetch instead.

The beat cadence is chosen at build time. In the registered mode, every beat spends one cycle with strobe low ahead of its strobe cycle. Against a zero-wait slave this gives 2-2-2-2 timing: eight clocks for a four-word line and three clocks for a single fetch, idle cycle included. The fast mode keeps strobe asserted and moves the address after every acknowledge. That gives 1-1-1-1 beats, a four-clock line and a two-clock single fetch. A second parameter sets how many cycles cyc stays low between separate transfers. An error answer on any beat ends the transfer at once and is reported without a completion pulse.

Top module: `line_fill_ctrl`

## Requirements
- R1: A request is taken only in a cycle where `ready` is high; a request in any other cycle is ignored and starts no bus activity.
- R2: A line fill reads WORDS words (default 4, each 32 bits) at addresses base, base+4, base+8, ..., where base is the request address with its low log2(WORDS*4) bits cleared.
- R3: `bus_cyc` stays high without a break from the first beat to the last acknowledge or error of a transfer, drops in the cycle after that response, and `bus_stb` is never high without `bus_cyc`.
- R4: With FAST=0, the first cycle of every beat has `bus_stb` low and the second has it high, so a zero-wait line fill holds `bus_cyc` for 8 cycles.
- R5: With FAST=1, `bus_stb` is high in every cycle that `bus_cyc` is high, so a zero-wait line fill holds `bus_cyc` for 4 cycles.
- R6: A single fetch performs exactly one beat, at the request address with bits [1:0] cleared, and delivers it with index 0.
- R7: For every acknowledged beat, `word_valid` is high for one cycle in the cycle after the acknowledge, with `word_data` equal to the data returned and `word_idx` equal to the beat number (0 for the first).
- R8: `fill_done` pulses together with the `word_valid` of the last beat. An `bus_err` on a beat instead gives a one-cycle `fill_err` in the next cycle with no `word_valid` and no `fill_done`, and no further beat is issued.
- R9: After a transfer ends, `bus_cyc` stays low for IDLE_GAP cycles (default 1), and `ready` is high only in the last of them and afterwards.
- R10: While reset is held and after its release, `bus_cyc`, `bus_stb`, `word_valid`, `fill_done` and `fill_err` are low and `ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request pulse from the cache |
| req_line | input | 1 | 1 = line fill, 0 = single word fetch |
| req_addr | input | ADDR_W | Byte address of the miss |
| ready | output | 1 | A request is accepted in this cycle |
| word_valid | output | 1 | Returned word present this cycle |
| word_idx | output | $clog2(WORDS) | Word position inside the line |
| word_data | output | DATA_W | Returned word |
| fill_done | output | 1 | Transfer completed with no error |
| fill_err | output | 1 | Transfer aborted by a bus error |
| bus_cyc | output | 1 | Bus cycle active |
| bus_stb | output | 1 | Beat strobe |
| bus_adr | output | ADDR_W | Beat byte address |
| bus_dat_i | input | DATA_W | Read data from memory |
| bus_ack | input | 1 | Beat acknowledge |
| bus_err | input | 1 | Beat error response |

## Verification
On every cycle the assertions check the handshake rules. They confirm that strobe is always inside cyc, that cyc falls only after a response, and that the address holds within a waiting beat. They also check that `ready` is never high during a bus cycle, that a word or error pulse follows its response by exactly one cycle, and that error and completion never appear together. They check the cadence of each mode: strobe low after every acknowledge in the registered mode, and strobe high throughout in the fast mode. Only the bench scenarios can show the actual beat addresses and data, the total clocks per line and per single fetch, the index order, the idle gap length and the dropping of requests made while busy. The bench compares all of these cycle by cycle against a timeline model for three build variants.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_BEAT  = 2'd2,
    ST_REST  = 2'd3
  } lfc_state_e;
endpackage

// File: rtl/lfc_beat_ctr.sv
module lfc_beat_ctr #(
  parameter int WORDS = 4,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output logic             at_end
);
  always_ff @(posedge clk) begin
    if (rst || clear) idx <= '0;
    else if (step)    idx <= IDX_W'(idx + 1'b1);
  end

  assign at_end = (idx == IDX_W'(WORDS - 1));
endmodule

// File: rtl/lfc_gap_timer.sv
module lfc_gap_timer #(
  parameter int GAP = 1,
  localparam int CW = (GAP > 1) ? $clog2(GAP) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (load)     cnt <= CW'(GAP - 1);
    else if (!expired) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/line_fill_ctrl.sv
module line_fill_ctrl #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int WORDS    = 4,
  parameter bit FAST     = 1'b0,
  parameter int IDLE_GAP = 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic                     req_line,
  input  logic [ADDR_W-1:0]        req_addr,
  output logic                     ready,
  output logic                     word_valid,
  output logic [$clog2(WORDS)-1:0] word_idx,
  output logic [DATA_W-1:0]        word_data,
  output logic                     fill_done,
  output logic                     fill_err,
  output logic                     bus_cyc,
  output logic                     bus_stb,
  output logic [ADDR_W-1:0]        bus_adr,
  input  logic [DATA_W-1:0]        bus_dat_i,
  input  logic                     bus_ack,
  input  logic                     bus_err
);
  import lfc_pkg::*;

  localparam int IDX_W      = $clog2(WORDS);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int LINE_BYTES = WORD_BYTES * WORDS;
  localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'(LINE_BYTES - 1);
  localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(WORD_BYTES - 1);

  lfc_state_e       state;
  logic             line_q;
  logic             accept;
  logic             resp;
  logic             last_beat;
  logic             step;
  logic             finish;
  logic             gap_over;
  logic [IDX_W-1:0] idx;
  logic             idx_end;

  assign ready     = (state == ST_IDLE) || ((state == ST_REST) && gap_over);
  assign accept    = ready && req_valid;
  assign resp      = (state == ST_BEAT) && (bus_ack || bus_err);
  assign last_beat = !line_q || idx_end;
  assign step      = (state == ST_BEAT) && bus_ack && !bus_err && !last_beat;
  assign finish    = resp && (bus_err || last_beat);

  lfc_beat_ctr #(.WORDS(WORDS)) u_beat (
    .clk    (clk),
    .rst    (rst),
    .clear  (accept),
    .step   (step),
    .idx    (idx),
    .at_end (idx_end)
  );

  lfc_gap_timer #(.GAP(IDLE_GAP)) u_gap (
    .clk     (clk),
    .rst     (rst),
    .load    (finish),
    .expired (gap_over)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      line_q     <= 1'b0;
      bus_cyc    <= 1'b0;
      bus_stb    <= 1'b0;
      bus_adr    <= '0;
      word_valid <= 1'b0;
      word_idx   <= '0;
      word_data  <= '0;
      fill_done  <= 1'b0;
      fill_err   <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      fill_done  <= 1'b0;
      fill_err   <= 1'b0;
      unique case (state)
        ST_IDLE, ST_REST: begin
          if (accept) begin
            line_q  <= req_line;
            bus_cyc <= 1'b1;
            bus_stb <= FAST;
            bus_adr <= req_addr & (req_line ? LINE_MASK : WORD_MASK);
            state   <= FAST ? ST_BEAT : ST_SETUP;
          end else if (state == ST_REST && gap_over) begin
            state <= ST_IDLE;
          end
        end
        ST_SETUP: begin
          bus_stb <= 1'b1;
          state   <= ST_BEAT;
        end
        ST_BEAT: begin
          if (bus_err) begin
            fill_err <= 1'b1;
            bus_cyc  <= 1'b0;
            bus_stb  <= 1'b0;
            state    <= ST_REST;
          end else if (bus_ack) begin
            word_valid <= 1'b1;
            word_idx   <= idx;
            word_data  <= bus_dat_i;
            if (last_beat) begin
              fill_done <= 1'b1;
              bus_cyc   <= 1'b0;
              bus_stb   <= 1'b0;
              state     <= ST_REST;
            end else begin
              bus_adr <= bus_adr + ADDR_W'(WORD_BYTES);
              bus_stb <= FAST;
              state   <= FAST ? ST_BEAT : ST_SETUP;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lfc_checker.sv
module lfc_checker #(
  parameter bit FAST   = 1'b0,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              ready,
  input logic              word_valid,
  input logic              fill_done,
  input logic              fill_err,
  input logic              bus_cyc,
  input logic              bus_stb,
  input logic [ADDR_W-1:0] bus_adr,
  input logic              bus_ack,
  input logic              bus_err
);
  // R3
  stb_inside_cyc_chk: assert property (@(posedge clk) disable iff (rst)
    bus_stb |-> bus_cyc);

  // R3
  cyc_drop_after_resp_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_cyc) |-> $past(bus_ack || bus_err));

  // R2
  adr_hold_in_beat_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && $past(bus_cyc) && !$past(bus_ack) && !$past(bus_err)) |-> $stable(bus_adr));

  // R1
  no_ready_in_cyc_chk: assert property (@(posedge clk) disable iff (rst)
    bus_cyc |-> !ready);

  // R7
  word_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> $past(bus_ack && bus_stb));

  // R8
  err_after_bus_err_chk: assert property (@(posedge clk) disable iff (rst)
    fill_err |-> $past(bus_err && bus_stb));

  // R8
  err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    fill_err |-> (!fill_done && !word_valid));

  generate
    if (FAST) begin : g_fast
      // R5
      fast_stb_held_chk: assert property (@(posedge clk) disable iff (rst)
        bus_cyc |-> bus_stb);
    end else begin : g_slow
      // R4
      slow_stb_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_cyc && $past(bus_ack && bus_stb)) |-> !bus_stb);
    end
  endgenerate
endmodule

bind line_fill_ctrl lfc_checker #(.FAST(FAST), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ready      (ready),
  .word_valid (word_valid),
  .fill_done  (fill_done),
  .fill_err   (fill_err),
  .bus_cyc    (bus_cyc),
  .bus_stb    (bus_stb),
  .bus_adr    (bus_adr),
  .bus_ack    (bus_ack),
  .bus_err    (bus_err)
);

// File: tb/tb_line_fill_ctrl.sv
module tb_line_fill_ctrl;
  localparam int NDUT = 3;
  localparam bit FASTV [NDUT] = '{1'b0, 1'b1, 1'b1};
  localparam int GAPV  [NDUT] = '{1, 1, 3};

  typedef struct {
    bit          cyc;
    bit          stb;
    logic [31:0] adr;
    bit          line;
    bit          wv;
    int          widx;
    logic [31:0] wdata;
    bit          done;
    bit          err;
    bit          rdy;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        req_valid [NDUT];
  logic        req_line  [NDUT];
  logic [31:0] req_addr  [NDUT];
  logic        ready     [NDUT];
  logic        word_valid[NDUT];
  logic [1:0]  word_idx  [NDUT];
  logic [31:0] word_data [NDUT];
  logic        fill_done [NDUT];
  logic        fill_err  [NDUT];
  logic        cyc       [NDUT];
  logic        stb       [NDUT];
  logic [31:0] adr       [NDUT];
  logic [31:0] rdata     [NDUT];
  logic        ack       [NDUT];
  logic        berr      [NDUT];
  logic [31:0] err_addr  [NDUT];

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h5A5A_0000;
  endfunction

  for (genvar g = 0; g < NDUT; g++) begin : gen_dut
    assign ack[g]   = cyc[g] & stb[g] & (adr[g] != err_addr[g]);
    assign berr[g]  = cyc[g] & stb[g] & (adr[g] == err_addr[g]);
    assign rdata[g] = memf(adr[g]);

    line_fill_ctrl #(.FAST(FASTV[g]), .IDLE_GAP(GAPV[g])) dut (
      .clk(clk), .rst(rst),
      .req_valid(req_valid[g]), .req_line(req_line[g]), .req_addr(req_addr[g]),
      .ready(ready[g]), .word_valid(word_valid[g]), .word_idx(word_idx[g]),
      .word_data(word_data[g]), .fill_done(fill_done[g]), .fill_err(fill_err[g]),
      .bus_cyc(cyc[g]), .bus_stb(stb[g]), .bus_adr(adr[g]),
      .bus_dat_i(rdata[g]), .bus_ack(ack[g]), .bus_err(berr[g])
    );
  end

  int   checks = 0;
  int   failures = 0;
  int   cycles = 0;
  exp_t q [NDUT][$];
  bit   exp_ready [NDUT];

  task automatic chk(input bit ok, input string tag, input int i, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s dut%0d cycle %0d %s actual=%h expected=%h", tag, i, cycles, what, act, exp);
    end
  endtask

  function automatic exp_t blank(input bit c, input bit s, input logic [31:0] a, input bit ln);
    exp_t e;
    e.cyc = c; e.stb = s; e.adr = a; e.line = ln; e.wv = 0; e.widx = 0;
    e.wdata = '0; e.done = 0; e.err = 0; e.rdy = 0;
    return e;
  endfunction

  bit          p_wv, p_done, p_err;
  int          p_idx;
  logic [31:0] p_data;

  task automatic push_with_pending(input int i, input exp_t e);
    exp_t x = e;
    x.wv = p_wv; x.widx = p_idx; x.wdata = p_data; x.done = p_done; x.err = p_err;
    p_wv = 0; p_done = 0; p_err = 0;
    q[i].push_back(x);
  endtask

  // Timeline of one accepted request for build variant i (zero-wait slave).
  task automatic build(input int i, input bit line, input logic [31:0] addr);
    logic [31:0] base = line ? (addr & ~32'hF) : (addr & ~32'h3);
    int n = line ? 4 : 1;
    p_wv = 0; p_done = 0; p_err = 0;
    for (int j = 0; j < n; j++) begin
      logic [31:0] a = base + 32'(4 * j);
      if (!FASTV[i]) push_with_pending(i, blank(1, 0, a, line));
      push_with_pending(i, blank(1, 1, a, line));
      if (a == err_addr[i]) begin
        p_err = 1;
        break;
      end
      p_wv = 1; p_idx = j; p_data = memf(a);
      if (j == n - 1) p_done = 1;
    end
    for (int k = 0; k < GAPV[i]; k++) begin
      exp_t e = blank(0, 0, '0, line);
      e.rdy = (k == GAPV[i] - 1);
      push_with_pending(i, e);
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < NDUT; i++) begin
        exp_t e;
        if (q[i].size() > 0) e = q[i].pop_front();
        else begin
          e = blank(0, 0, '0, 0);
          e.rdy = 1;
        end
        exp_ready[i] = e.rdy;
        chk(cyc[i] == e.cyc, "R3", i, "bus_cyc", 32'(cyc[i]), 32'(e.cyc));
        chk(stb[i] == e.stb, FASTV[i] ? "R5" : "R4", i, "bus_stb", 32'(stb[i]), 32'(e.stb));
        if (e.cyc)
          chk(adr[i] == e.adr, e.line ? "R2" : "R6", i, "bus_adr", adr[i], e.adr);
        chk(word_valid[i] == e.wv, "R7", i, "word_valid", 32'(word_valid[i]), 32'(e.wv));
        if (e.wv) begin
          chk(word_data[i] == e.wdata, "R7", i, "word_data", word_data[i], e.wdata);
          chk(int'(word_idx[i]) == e.widx, e.line ? "R2" : "R6", i, "word_idx",
              32'(word_idx[i]), 32'(e.widx));
        end
        chk(fill_done[i] == e.done, "R8", i, "fill_done", 32'(fill_done[i]), 32'(e.done));
        chk(fill_err[i] == e.err, "R8", i, "fill_err", 32'(fill_err[i]), 32'(e.err));
        chk(ready[i] == e.rdy, "R9", i, "ready", 32'(ready[i]), 32'(e.rdy));
      end
    end
  end

  // R1: a request is offered every time; the model only takes it when ready.
  task automatic offer(input int i, input bit line, input logic [31:0] addr);
    @(negedge clk); #1;
    if (exp_ready[i]) build(i, line, addr);
    req_valid[i] = 1'b1; req_line[i] = line; req_addr[i] = addr;
  endtask

  task automatic release_req(input int i);
    @(negedge clk); #1;
    req_valid[i] = 1'b0;
  endtask

  task automatic settle();
    repeat (16) @(posedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NDUT; i++) begin
      req_valid[i] = 0; req_line[i] = 0; req_addr[i] = '0;
      err_addr[i] = 32'h1; exp_ready[i] = 1;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < NDUT; i++) begin
      // R10 reset state
      chk(!cyc[i] && !stb[i] && !word_valid[i] && !fill_done[i] && !fill_err[i] && ready[i],
          "R10", i, "reset outputs", {cyc[i], stb[i], word_valid[i], fill_done[i], fill_err[i], ready[i]},
          32'h1);
    end
    #1 rst = 1'b0;
    settle();
    for (int i = 0; i < NDUT; i++) begin
      // R2 line fill, unaligned request address
      offer(i, 1, 32'h0000_100C); release_req(i); settle();
      // R6 single fetch, low bits cleared
      offer(i, 0, 32'h0000_2007); release_req(i); settle();
      // R1 requests every cycle; those made while busy must be dropped
      for (int k = 0; k < 14; k++) offer(i, (k % 3) == 0, 32'h300 + 32'(k * 4));
      release_req(i); settle();
      // R8 error on third beat of a line
      err_addr[i] = 32'h0000_4008;
      offer(i, 1, 32'h0000_4000); release_req(i); settle();
      // R8 error on a single fetch
      err_addr[i] = 32'h0000_5004;
      offer(i, 0, 32'h0000_5006); release_req(i); settle();
      err_addr[i] = 32'h1;
      // R2 line at the top of the address space
      offer(i, 1, 32'hFFFF_FFF4); release_req(i); settle();
      // R9 single fetches back to back to expose the idle gap
      offer(i, 0, 32'h0000_6000); offer(i, 0, 32'h0000_6004);
      offer(i, 0, 32'h0000_6008); offer(i, 0, 32'h0000_600C);
      release_req(i); settle();
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule